// File: doc/BRIEF.md
# Quasi-bidirectional I2C port expander

This block is an I2C target that gives a host 8 or 16 general-purpose pins, with the count set by a parameter. It has no register pointer and no direction register. Every data byte the host writes goes straight into one output latch. Every read returns the levels actually present on the pins. The latch value alone sets how each pin behaves. A latch bit of 0 pulls its pin low. A latch bit of 1 lets the pin float up to a weak high, so an outside source can pull it down and the pin then works as an input.

The block runs on a fast system clock and oversamples the bus. SCL, SDA and the pin inputs each pass through a two-flop synchronizer. SDA and the interrupt line are reported as open-drain pull requests: when one of these outputs is 1, the line should be pulled low. The interrupt flags any synchronized pin whose level differs from the value captured at the last read. Pins can be shared between several expanders, since each one only ever pulls low.

Top module: `qbio_expander`

## Requirements
- R1: After reset no pin is pulled low (`pin_drive_low` = 0), SDA is released and the interrupt is released.
- R2: The target acknowledges only the 7-bit address `{BASE[6:3], addr_sel}`, where BASE is 0x20 when ADDR_ALT=0 and 0x38 when ADDR_ALT=1. Any other address gets no acknowledge and changes nothing.
- R3: Written bytes go directly into the latch with no pointer byte. For every pin i, `pin_drive_low[i]` is the inverse of latch bit i.
- R4: With NPINS=16, a write carries bytes in pairs, pins 7..0 first and then pins 15..8. The latch changes only once the second byte of a pair is acknowledged. A lone first byte followed by STOP leaves the latch unchanged. Further pairs in the same transfer update the latch in turn.
- R5: With NPINS=8, every acknowledged data byte updates the latch, and consecutive bytes in one transfer each overwrite it.
- R6: A read returns the synchronized pin levels captured at the address acknowledge, never the latch. Pins 7..0 come first. A pin held low from outside reads as 0.
- R7: `irq_pull_low` rises within 4 clocks of a pin level that differs from the captured value.
- R8: `irq_pull_low` falls when a read captures the pins, or when the pins return to the captured value.
- R9: SDA changes only while SCL is low. After the host answers a read byte with NACK, the target releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sensed bus clock level |
| sda_in | input | 1 | Sensed bus data level |
| sda_pull_low | output | 1 | 1 = pull SDA low (open-drain) |
| addr_sel | input | 3 | Low three bits of the target address |
| pin_in | input | NPINS | Sensed pin levels |
| pin_drive_low | output | NPINS | 1 = pin actively pulled low |
| irq_pull_low | output | 1 | 1 = pull the shared interrupt line low |

## Verification
The hardest case to reach is an interrupt that must clear while a pin still differs from its latch value. The only thing that clears it is the capture at a read's address acknowledge, and the read has to happen while the external pull is still applied. The bench holds an external low on a released pin, issues a full read, and checks that the interrupt drops and that the returned word shows the pulled pin. A second awkward case is a 16-pin write stopped after one byte. The bench sends such a transfer and then shows through the pin outputs that the latch kept its old value. A second expander of the other width and address variant shares the bus, so the bench exercises cross-address rejection on every transfer.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } qbio_st_t;

  // upper four address bits for the two address variants
  function automatic logic [3:0] addr_high(input bit alt);
    return alt ? 4'b0111 : 4'b0100;
  endfunction

endpackage

// File: rtl/qbio_sync.sv
module qbio_sync #(
  parameter int            W    = 1,
  parameter logic [W-1:0]  RVAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RVAL;
      q    <= RVAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/qbio_i2c_target.sv
module qbio_i2c_target
  import qbio_pkg::*;
#(
  parameter bit ADDR_ALT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic [2:0] addr_sel,
  input  logic [7:0] tx_data,
  output logic       sda_pull_low,
  output logic       txn_start,
  output logic       rd_cap,
  output logic       rx_stb,
  output logic [7:0] rx_data,
  output logic       tx_adv
);
  localparam logic [3:0] AHI = addr_high(ADDR_ALT);

  qbio_st_t   st;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       rw_q, ack_q;
  logic       scl_d, sda_d;
  logic       scl_rise, scl_fall, bus_start, bus_stop;
  logic [6:0] my_addr;

  assign my_addr   = {AHI, addr_sel};
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
  assign rx_data   = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      sh           <= '0;
      cnt          <= '0;
      rw_q         <= 1'b0;
      ack_q        <= 1'b0;
      scl_d        <= 1'b1;
      sda_d        <= 1'b1;
      sda_pull_low <= 1'b0;
      txn_start    <= 1'b0;
      rd_cap       <= 1'b0;
      rx_stb       <= 1'b0;
      tx_adv       <= 1'b0;
    end else begin
      scl_d     <= scl_s;
      sda_d     <= sda_s;
      txn_start <= 1'b0;
      rd_cap    <= 1'b0;
      rx_stb    <= 1'b0;
      tx_adv    <= 1'b0;
      if (bus_start) begin
        st           <= ST_ADDR;
        cnt          <= '0;
        sda_pull_low <= 1'b0;
      end else if (bus_stop) begin
        st           <= ST_IDLE;
        sda_pull_low <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sh[7:1] == my_addr) begin
                st           <= ST_ADDR_ACK;
                sda_pull_low <= 1'b1;
                rw_q         <= sh[0];
                txn_start    <= 1'b1;
                rd_cap       <= sh[0];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw_q) begin
                st           <= ST_TX;
                sh           <= tx_data;
                sda_pull_low <= ~tx_data[7];
              end else begin
                st           <= ST_RX;
                sda_pull_low <= 1'b0;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              st           <= ST_RX_ACK;
              sda_pull_low <= 1'b1;
              rx_stb       <= 1'b1;
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              st           <= ST_RX;
              cnt          <= '0;
              sda_pull_low <= 1'b0;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                st           <= ST_TX_ACK;
                sda_pull_low <= 1'b0;
              end else begin
                sda_pull_low <= ~sh[6];
                sh           <= {sh[6:0], 1'b0};
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              ack_q  <= ~sda_s;
              tx_adv <= ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (ack_q) begin
                st           <= ST_TX;
                sh           <= tx_data;
                sda_pull_low <= ~tx_data[7];
              end else begin
                st           <= ST_IDLE;
                sda_pull_low <= 1'b0;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/qbio_port.sv
module qbio_port #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins_s,
  input  logic             txn_start,
  input  logic             rd_cap,
  input  logic             rx_stb,
  input  logic [7:0]       rx_data,
  input  logic             tx_adv,
  output logic [7:0]       tx_data,
  output logic [NPINS-1:0] pin_drive_low,
  output logic             irq_pull_low
);
  logic [NPINS-1:0] cap, cap_nxt, drv_q;

  assign cap_nxt       = rd_cap ? pins_s : cap;
  assign pin_drive_low = drv_q;

  // snapshot used both for read data and change detection
  always_ff @(posedge clk) begin
    if (rst) begin
      cap          <= '1;
      irq_pull_low <= 1'b0;
    end else begin
      cap          <= cap_nxt;
      irq_pull_low <= (pins_s != cap_nxt);
    end
  end

  generate
    if (NPINS == 16) begin : g_wide
      logic       lo_have;
      logic [7:0] lo_q;
      logic       tx_hi;

      always_ff @(posedge clk) begin
        if (rst) begin
          lo_have <= 1'b0;
          lo_q    <= '0;
          tx_hi   <= 1'b0;
          drv_q   <= '0;
        end else if (txn_start) begin
          lo_have <= 1'b0;
          tx_hi   <= 1'b0;
        end else begin
          if (rx_stb) begin
            if (!lo_have) begin
              lo_q    <= rx_data;
              lo_have <= 1'b1;
            end else begin
              drv_q   <= ~{rx_data, lo_q};
              lo_have <= 1'b0;
            end
          end
          if (tx_adv) tx_hi <= ~tx_hi;
        end
      end

      assign tx_data = tx_hi ? cap[15:8] : cap[7:0];
    end else begin : g_narrow
      always_ff @(posedge clk) begin
        if (rst)         drv_q <= '0;
        else if (rx_stb) drv_q <= ~rx_data;
      end

      assign tx_data = cap[7:0];
    end
  endgenerate
endmodule

// File: rtl/qbio_expander.sv
module qbio_expander #(
  parameter int NPINS    = 16,
  parameter bit ADDR_ALT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull_low,
  input  logic [2:0]       addr_sel,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_drive_low,
  output logic             irq_pull_low
);
  logic             scl_s, sda_s;
  logic [NPINS-1:0] pins_s;
  logic             txn_start, rd_cap, rx_stb, tx_adv;
  logic [7:0]       rx_data, tx_data;

  qbio_sync #(.W(2), .RVAL(2'b11)) u_bus_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   ({scl_s, sda_s})
  );

  qbio_sync #(.W(NPINS), .RVAL({NPINS{1'b1}})) u_pin_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pins_s)
  );

  qbio_i2c_target #(.ADDR_ALT(ADDR_ALT)) u_target (
    .clk          (clk),
    .rst          (rst),
    .scl_s        (scl_s),
    .sda_s        (sda_s),
    .addr_sel     (addr_sel),
    .tx_data      (tx_data),
    .sda_pull_low (sda_pull_low),
    .txn_start    (txn_start),
    .rd_cap       (rd_cap),
    .rx_stb       (rx_stb),
    .rx_data      (rx_data),
    .tx_adv       (tx_adv)
  );

  qbio_port #(.NPINS(NPINS)) u_port (
    .clk           (clk),
    .rst           (rst),
    .pins_s        (pins_s),
    .txn_start     (txn_start),
    .rd_cap        (rd_cap),
    .rx_stb        (rx_stb),
    .rx_data       (rx_data),
    .tx_adv        (tx_adv),
    .tx_data       (tx_data),
    .pin_drive_low (pin_drive_low),
    .irq_pull_low  (irq_pull_low)
  );
endmodule

// File: rtl/qbio_expander_chk.sv
module qbio_expander_chk #(
  parameter int NPINS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_s,
  input logic             sda_pull_low,
  input logic [NPINS-1:0] pin_drive_low,
  input logic             irq_pull_low,
  input logic             rx_stb,
  input logic             rd_cap
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_drive_low == '0 && !sda_pull_low && !irq_pull_low)); // R1

  AST_LATCH_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_stb) |-> $stable(pin_drive_low)); // R3

  AST_IRQ_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    $past(rd_cap) |-> !irq_pull_low); // R8

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_low) |-> !scl_s); // R9
endmodule

bind qbio_expander qbio_expander_chk #(.NPINS(NPINS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .scl_s         (scl_s),
  .sda_pull_low  (sda_pull_low),
  .pin_drive_low (pin_drive_low),
  .irq_pull_low  (irq_pull_low),
  .rx_stb        (rx_stb),
  .rd_cap        (rd_cap)
);

// File: tb/qbio_expander_test.sv
module qbio_expander_test;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        scl   = 1'b1;
  logic        m_low = 1'b0;
  logic [2:0]  sel   = 3'd0;
  logic [15:0] ext   = '0;
  logic [7:0]  ext8  = '0;
  wire  [15:0] drv;
  wire  [7:0]  drv8;
  wire         s_low, s8_low, irq, irq8;
  wire         sda   = ~(m_low | s_low | s8_low);
  wire  [15:0] pins  = ~(drv | ext);
  wire  [7:0]  pins8 = ~(drv8 | ext8);

  qbio_expander #(.NPINS(16), .ADDR_ALT(1'b0)) uut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .sda_pull_low(s_low),
    .addr_sel(sel), .pin_in(pins), .pin_drive_low(drv), .irq_pull_low(irq)
  );

  qbio_expander #(.NPINS(8), .ADDR_ALT(1'b1)) uut8 (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .sda_pull_low(s8_low),
    .addr_sel(3'b010), .pin_in(pins8), .pin_drive_low(drv8), .irq_pull_low(irq8)
  );

  int tests = 0;
  int fails = 0;
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hb();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; hb();
    scl = 1'b1;   hb();
    m_low = 1'b1; hb();
    scl = 1'b0;   hb();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; hb();
    scl = 1'b1;   hb();
    m_low = 1'b0; hb();
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; hb();
    scl = 1'b1; hb(); hb();
    scl = 1'b0; hb();
  endtask

  task automatic recv_bit(output logic b);
    m_low = 1'b0; hb();
    scl = 1'b1;   hb();
    b = sda;      hb();
    scl = 1'b0;   hb();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~ack);
  endtask

  task automatic xfer_wr(input logic [6:0] a, input int n, output logic aok);
    logic k;
    bus_start();
    send_byte({a, 1'b0}, aok);
    if (aok) for (int i = 0; i < n; i++) send_byte(wbuf[i], k);
    bus_stop();
  endtask

  task automatic xfer_rd(input logic [6:0] a, input int n, output logic aok, output logic rel);
    bus_start();
    send_byte({a, 1'b1}, aok);
    rel = 1'b1;
    if (aok) begin
      for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
      rel = ~s_low & ~s8_low;
    end
    bus_stop();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic ok, rel;
    logic [15:0] v, e;
    void'($urandom(32'h0005_EED1));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 drv", {16'h0, drv}, 32'h0);
    chk("R1 drv8", {24'h0, drv8}, 32'h0);
    chk("R1 sda", {31'h0, s_low | s8_low}, 32'h0);
    chk("R1 irq", {31'h0, irq | irq8}, 32'h0);

    // R2 R4 pair write, low byte first
    wbuf[0] = 8'hF0; wbuf[1] = 8'h12;
    xfer_wr(7'h20, 2, ok);
    chk("R2 ack 0x20", {31'h0, ok}, 32'h1);
    chk("R4 pair write", {16'h0, drv}, {16'h0, ~16'h12F0});

    // R6 read of pin levels, R9 release after nack
    xfer_rd(7'h20, 2, ok, rel);
    chk("R6 read", {16'h0, rbuf[1], rbuf[0]}, 32'h12F0);
    chk("R9 release", {31'h0, rel}, 32'h1);
    repeat (6) @(negedge clk);
    chk("R8 irq after read", {31'h0, irq}, 32'h0);

    // R7 R8 interrupt on change and on return
    ext = 16'h0010;
    repeat (8) @(negedge clk);
    chk("R7 irq set", {31'h0, irq}, 32'h1);
    ext = 16'h0000;
    repeat (8) @(negedge clk);
    chk("R8 irq return", {31'h0, irq}, 32'h0);

    // R8 read clears while the external pull is still held
    ext = 16'h0200;
    repeat (8) @(negedge clk);
    chk("R7 irq set hi", {31'h0, irq}, 32'h1);
    xfer_rd(7'h20, 2, ok, rel);
    chk("R6 ext low", {16'h0, rbuf[1], rbuf[0]}, 32'h10F0);
    chk("R8 irq read clr", {31'h0, irq}, 32'h0);
    ext = 16'h0000;
    xfer_rd(7'h20, 2, ok, rel);

    // R4 lone first byte leaves latch
    wbuf[0] = 8'h00;
    xfer_wr(7'h20, 1, ok);
    chk("R4 lone byte", {16'h0, drv}, {16'h0, ~16'h12F0});

    // R2 foreign address
    wbuf[0] = 8'h00; wbuf[1] = 8'h00;
    xfer_wr(7'h21, 2, ok);
    chk("R2 nack 0x21", {31'h0, ok}, 32'h0);
    chk("R2 no effect", {16'h0, drv}, {16'h0, ~16'h12F0});
    chk("R2 no effect 8", {24'h0, drv8}, 32'h0);

    // R2 R3 address select
    sel = 3'd5;
    wbuf[0] = 8'hC3; wbuf[1] = 8'hA5;
    xfer_wr(7'h25, 2, ok);
    chk("R2 ack 0x25", {31'h0, ok}, 32'h1);
    chk("R3 latch", {16'h0, drv}, {16'h0, ~16'hA5C3});
    xfer_wr(7'h20, 2, ok);
    chk("R2 old addr nack", {31'h0, ok}, 32'h0);

    // R4 two pairs in one transfer
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    xfer_wr(7'h25, 4, ok);
    chk("R4 two pairs", {16'h0, drv}, {16'h0, ~16'h4433});

    // R5 narrow, alternate address
    wbuf[0] = 8'h5A;
    xfer_wr(7'h3A, 1, ok);
    chk("R2 ack alt 0x3A", {31'h0, ok}, 32'h1);
    chk("R5 single byte", {24'h0, drv8}, 32'hA5);
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h80;
    xfer_wr(7'h3A, 3, ok);
    chk("R5 byte stream", {24'h0, drv8}, 32'h7F);
    chk("R2 wide untouched", {16'h0, drv}, {16'h0, ~16'h4433});
    xfer_wr(7'h22, 1, ok);
    chk("R2 nack 0x22", {31'h0, ok}, 32'h0);
    xfer_rd(7'h3A, 1, ok, rel);
    chk("R6 narrow read", {24'h0, rbuf[0]}, 32'h80);
    chk("R9 narrow release", {31'h0, rel}, 32'h1);

    // random latch and external pull patterns
    for (int it = 0; it < 20; it++) begin
      v = 16'($urandom);
      e = 16'($urandom) & 16'($urandom);
      wbuf[0] = v[7:0]; wbuf[1] = v[15:8];
      xfer_wr(7'h25, 2, ok);
      chk("R3 random latch", {16'h0, drv}, {16'h0, ~v});
      ext = e;
      repeat (4) @(negedge clk);
      xfer_rd(7'h25, 2, ok, rel);
      chk("R6 random read", {16'h0, rbuf[1], rbuf[0]}, {16'h0, v & ~e});
      ext = 16'h0000;
    end

    summary();
    $finish;
  end
endmodule